// File: doc/BRIEF.md
# Accumulator overflow flagging and saturation

This block sits beside a multiply-accumulate datapath that owns a small bank of 52-bit accumulators. An accumulator is built from a high word, a low word and a 4-bit extension. The block watches each 52-bit sum as it is written into the selected accumulator. For every accumulator it keeps an overflow flag. It also keeps one sticky flag that records a true loss of sign in the 52-bit sum.

The threshold for the overflow flag depends on the operating mode. In wide (24-bit) mode the flag is set when the sum leaves the 48-bit range. In narrow (16-bit) mode the extension is unused and the top byte of the high word serves as the guard bits, so the flag is set when the sum leaves the 40-bit range.

The block also serves two saturation paths. A saturate command asks for an overflowed accumulator to be replaced by the limit value for the current mode. The block presents that value with a write enable and clears the flag. A read of the high word onto the data bus is clamped to the limit value when protection is enabled and the selected accumulator has overflowed. That path leaves the stored contents untouched. The arithmetic and the accumulator storage are outside the block.

Top module: `acc_ovf_sat`

## Requirements
- R1: In wide mode (`mode16`=0), an `acc_wr` cycle loads the overflow flag of accumulator `bank_sel` at the next clock edge. The flag becomes 1 if bits 51 down to 47 of `sum_result` are not all equal and 0 otherwise. The flags of the other accumulators are not changed.
- R2: In narrow mode (`mode16`=1), an `acc_wr` cycle loads the flag in the same way, but compares bits 51 down to 39.
- R3: After reset all overflow flags and the memorized flag are 0. An overflow flag changes only on an `acc_wr` to its own accumulator or on an effective saturate of that accumulator.
- R4: `mv_flag` becomes 1 after any `acc_wr` cycle in which `sum_cin_msb` differs from `sum_cout_msb`. It stays 1 until a `mv_clr` cycle, and a set in the same cycle wins over the clear.
- R5: `sat_we` is 1 only when `sat_cmd` is 1 and the flag of accumulator `bank_sel` is 1. Whenever `sat_we` is 0, `sat_value` equals `acc_cur`.
- R6: In wide mode, an effective saturate outputs 0_7FFF_FFFF_FFFFh when `acc_cur[51]` is 0 and F_8000_0000_0000h when it is 1. Both values are 52-bit hex.
- R7: In narrow mode, an effective saturate outputs 0_007F_FFFF_FF00h for a positive sign and F_FF80_0000_0000h for a negative sign.
- R8: An effective saturate clears the flag of accumulator `bank_sel` at the next edge. If `acc_wr` is also 1 in that cycle, the R1/R2 update takes precedence.
- R9: `rd_data` equals `acc_cur[47:24]` unless `prot_en` and the flag of accumulator `bank_sel` are both 1. When both are 1 in wide mode, it is 7FFFFFh for a positive `acc_cur[51]` and 800000h for a negative one.
- R10: When a high-word read is clamped in narrow mode, `rd_data` is 007FFFh for a positive sign and FF8000h for a negative sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode16 | input | 1 | 1 selects narrow (16-bit) mode, 0 selects wide mode |
| bank_sel | input | 1 | Selected accumulator |
| prot_en | input | 1 | Enables clamping of high-word reads |
| acc_wr | input | 1 | Sum is being written into the selected accumulator |
| sum_result | input | 52 | Adder result being written |
| sum_cin_msb | input | 1 | Carry into bit 51 of the adder |
| sum_cout_msb | input | 1 | Carry out of bit 51 of the adder |
| acc_cur | input | 52 | Current contents of the selected accumulator |
| sat_cmd | input | 1 | Saturate command strobe |
| mv_clr | input | 1 | Clears the memorized overflow flag |
| vm_flags | output | 2 | Overflow flag per accumulator |
| mv_flag | output | 1 | Memorized (sticky) overflow flag |
| sat_we | output | 1 | Saturated value must be written back |
| sat_value | output | 52 | Value to write back |
| rd_data | output | 24 | High-word read data |

## Verification
The sums used for flagging lie just inside and just outside each mode's threshold. An example is F_8000_0000_0000h against 0_8000_0000_0000h. These pairs separate a correct bit range from one that is off by one, and from one that checks the wrong mode.

Saturate commands and clamped reads are run with both signs and in both modes, so that each limit constant and the sign source are checked one at a time. Commands given while the flag is clear show that the command is gated.

Carry pairs that disagree, followed by clears and by a clear given together with a set, check that the memorized flag is sticky and that a set wins over a clear. A long random mix of all strobes is compared against the reference model on every cycle.

// File: rtl/acc_sat_pkg.sv
// Package: shared types for the accumulator overflow/saturation block.
// Assumes: the accumulator is laid out as extension : high word : low word.
package acc_sat_pkg;
    typedef enum logic {
        MODE_WIDE   = 1'b0,
        MODE_NARROW = 1'b1
    } acc_mode_e;
endpackage

// File: rtl/acc_spill_detect.sv
// Module: acc_spill_detect
// Works out, for one adder result, whether it leaves the wide-mode range or
// the narrow-mode range, and whether the addition lost its true sign.
// Assumes: the carries into and out of the top bit come from the adder.
module acc_spill_detect #(
    parameter int ACC_W     = 52,
    parameter int WIDE_TH   = 47,
    parameter int NARROW_TH = 39
) (
    input  logic [ACC_W-1:0] result,
    input  logic             cin_msb,
    input  logic             cout_msb,
    output logic             spill_wide,
    output logic             spill_narrow,
    output logic             sign_lost
);
    localparam int WIDE_N   = ACC_W - WIDE_TH;
    localparam int NARROW_N = ACC_W - NARROW_TH;

    logic [WIDE_N-1:0]   top_wide;
    logic [NARROW_N-1:0] top_narrow;

    // Purpose: flag a result whose guard bits are not all copies of the sign.
    always_comb begin
        top_wide     = result[ACC_W-1:WIDE_TH];
        top_narrow   = result[ACC_W-1:NARROW_TH];
        spill_wide   = !((&top_wide) || !(|top_wide));
        spill_narrow = !((&top_narrow) || !(|top_narrow));
        sign_lost    = cin_msb ^ cout_msb;
    end
endmodule

// File: rtl/acc_flag_bank.sv
// Module: acc_flag_bank
// Holds one overflow flag per accumulator and the sticky memorized flag.
// Assumes: an accumulate write takes precedence over a saturate clear on the
// same accumulator, and a set of the sticky flag wins over its clear.
module acc_flag_bank #(
    parameter int NUM_ACC = 2,
    parameter int BANK_W  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_wr,
    input  logic [BANK_W-1:0]  bank_sel,
    input  logic               spill,
    input  logic               sign_lost,
    input  logic               sat_done,
    input  logic               mv_clr,
    output logic [NUM_ACC-1:0] vm_flags,
    output logic               mv_flag
);
    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        logic hit;
        assign hit = (bank_sel == BANK_W'(g));

        // Purpose: update the overflow flag of accumulator g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vm_flags[g] <= 1'b0;
            end else if (acc_wr && hit) begin
                vm_flags[g] <= spill;
            end else if (sat_done && hit) begin
                vm_flags[g] <= 1'b0;
            end
        end
    end

    // Purpose: latch any loss of sign until it is explicitly cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mv_flag <= 1'b0;
        end else if (acc_wr && sign_lost) begin
            mv_flag <= 1'b1;
        end else if (mv_clr) begin
            mv_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/acc_sat_mux.sv
// Module: acc_sat_mux
// Selects the mode-dependent limit values for the saturate command and for
// clamped high-word reads. It is purely combinational.
// Assumes: the sign of the stored accumulator is its top bit.
module acc_sat_mux #(
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 16,
    parameter int EXT_W    = 4
) (
    input  logic [2*WORD_W+EXT_W-1:0] acc_cur,
    input  acc_sat_pkg::acc_mode_e    mode,
    input  logic                      vm_sel,
    input  logic                      prot_en,
    input  logic                      sat_cmd,
    output logic                      sat_we,
    output logic [2*WORD_W+EXT_W-1:0] sat_value,
    output logic [WORD_W-1:0]         rd_data
);
    import acc_sat_pkg::*;

    localparam int ACC_W     = 2*WORD_W + EXT_W;
    localparam int WIDE_TH   = 2*WORD_W - 1;
    localparam int NARROW_TH = WORD_W + NARROW_W - 1;
    localparam int LOW_PAD   = WORD_W - NARROW_W;
    localparam logic [ACC_W-1:0] ONE        = ACC_W'(1);
    localparam logic [ACC_W-1:0] POS_WIDE   = (ONE << WIDE_TH) - ONE;
    localparam logic [ACC_W-1:0] NEG_WIDE   = ~POS_WIDE;
    localparam logic [ACC_W-1:0] PAD_MASK   = (ONE << LOW_PAD) - ONE;
    localparam logic [ACC_W-1:0] POS_NARROW = ((ONE << NARROW_TH) - ONE) & ~PAD_MASK;
    localparam logic [ACC_W-1:0] NEG_NARROW = ~((ONE << NARROW_TH) - ONE);

    logic             neg;
    logic [ACC_W-1:0] limit;

    // Purpose: choose the full-width limit from the mode and the sign.
    always_comb begin
        neg = acc_cur[ACC_W-1];
        if (mode == MODE_NARROW) begin
            limit = neg ? NEG_NARROW : POS_NARROW;
        end else begin
            limit = neg ? NEG_WIDE : POS_WIDE;
        end
    end

    // Purpose: drive the write-back value and the high-word read data.
    always_comb begin
        sat_we    = sat_cmd && vm_sel;
        sat_value = sat_we ? limit : acc_cur;
        rd_data   = (prot_en && vm_sel) ? limit[2*WORD_W-1:WORD_W]
                                        : acc_cur[2*WORD_W-1:WORD_W];
    end
endmodule

// File: rtl/acc_ovf_sat.sv
// Module: acc_ovf_sat (top)
// Flags accumulator overflow per accumulator, keeps a sticky flag for loss of
// sign, and produces saturated write-back and clamped read values.
// Assumes: the accumulator storage and the adder are outside the block, and
// acc_cur shows the accumulator picked by bank_sel.
module acc_ovf_sat #(
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 16,
    parameter int EXT_W    = 4,
    parameter int NUM_ACC  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode16,
    input  logic [$clog2(NUM_ACC)-1:0] bank_sel,
    input  logic                      prot_en,
    input  logic                      acc_wr,
    input  logic [2*WORD_W+EXT_W-1:0] sum_result,
    input  logic                      sum_cin_msb,
    input  logic                      sum_cout_msb,
    input  logic [2*WORD_W+EXT_W-1:0] acc_cur,
    input  logic                      sat_cmd,
    input  logic                      mv_clr,
    output logic [NUM_ACC-1:0]        vm_flags,
    output logic                      mv_flag,
    output logic                      sat_we,
    output logic [2*WORD_W+EXT_W-1:0] sat_value,
    output logic [WORD_W-1:0]         rd_data
);
    import acc_sat_pkg::*;

    localparam int ACC_W     = 2*WORD_W + EXT_W;
    localparam int BANK_W    = $clog2(NUM_ACC);
    localparam int WIDE_TH   = 2*WORD_W - 1;
    localparam int NARROW_TH = WORD_W + NARROW_W - 1;

    acc_mode_e mode;
    logic      spill_wide, spill_narrow, sign_lost, spill, vm_sel;

    // Purpose: decode the mode and pick the threshold and the selected flag.
    always_comb begin
        mode   = mode16 ? MODE_NARROW : MODE_WIDE;
        spill  = (mode == MODE_NARROW) ? spill_narrow : spill_wide;
        vm_sel = vm_flags[bank_sel];
    end

    acc_spill_detect #(
        .ACC_W(ACC_W), .WIDE_TH(WIDE_TH), .NARROW_TH(NARROW_TH)
    ) i_detect (
        .result(sum_result), .cin_msb(sum_cin_msb), .cout_msb(sum_cout_msb),
        .spill_wide(spill_wide), .spill_narrow(spill_narrow),
        .sign_lost(sign_lost)
    );

    acc_flag_bank #(.NUM_ACC(NUM_ACC), .BANK_W(BANK_W)) i_flags (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .bank_sel(bank_sel),
        .spill(spill), .sign_lost(sign_lost), .sat_done(sat_we),
        .mv_clr(mv_clr), .vm_flags(vm_flags), .mv_flag(mv_flag)
    );

    acc_sat_mux #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .EXT_W(EXT_W)) i_mux (
        .acc_cur(acc_cur), .mode(mode), .vm_sel(vm_sel), .prot_en(prot_en),
        .sat_cmd(sat_cmd), .sat_we(sat_we), .sat_value(sat_value),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/acc_ovf_sat_chk.sv
// Module: acc_ovf_sat_chk
// Property checker bound to acc_ovf_sat. It observes the ports only.
module acc_ovf_sat_chk #(
    parameter int WORD_W = 24,
    parameter int ACC_W  = 52,
    parameter int NUM_ACC = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [$clog2(NUM_ACC)-1:0] bank_sel,
    input logic                       prot_en,
    input logic                       acc_wr,
    input logic                       sum_cin_msb,
    input logic                       sum_cout_msb,
    input logic [ACC_W-1:0]           acc_cur,
    input logic                       sat_cmd,
    input logic                       mv_clr,
    input logic [NUM_ACC-1:0]         vm_flags,
    input logic                       mv_flag,
    input logic                       sat_we,
    input logic [WORD_W-1:0]          rd_data
);
    // R4: the memorized flag stays set until it is cleared.
    p_mv_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mv_flag && !mv_clr |=> mv_flag);

    // R4: a loss of sign during a write is remembered.
    p_mv_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr && (sum_cin_msb != sum_cout_msb) |=> mv_flag);

    // R5: a write-back happens only for an overflowed accumulator.
    p_sat_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sat_we |-> (sat_cmd && vm_flags[bank_sel]));

    // R8: an effective saturate without a write clears the flag.
    p_sat_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sat_we && !acc_wr |=> !vm_flags[$past(bank_sel)]);

    // R3: the flags hold when there is neither a write nor a saturate.
    p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr && !sat_cmd |=> $stable(vm_flags));

    // R9: reads pass through unchanged when protection is off.
    p_rd_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |-> rd_data == acc_cur[2*WORD_W-1:WORD_W]);
endmodule

bind acc_ovf_sat acc_ovf_sat_chk #(
    .WORD_W(WORD_W), .ACC_W(ACC_W), .NUM_ACC(NUM_ACC)
) i_acc_ovf_sat_chk (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .prot_en(prot_en),
    .acc_wr(acc_wr), .sum_cin_msb(sum_cin_msb), .sum_cout_msb(sum_cout_msb),
    .acc_cur(acc_cur), .sat_cmd(sat_cmd), .mv_clr(mv_clr),
    .vm_flags(vm_flags), .mv_flag(mv_flag), .sat_we(sat_we), .rd_data(rd_data)
);

// File: tb/test_acc_ovf_sat.sv
// Bench for acc_ovf_sat: a behavioural reference model, compared every cycle.
module test_acc_ovf_sat;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode16 = 1'b0, bank_sel = 1'b0, prot_en = 1'b0;
    logic        acc_wr = 1'b0, sum_cin_msb = 1'b0, sum_cout_msb = 1'b0;
    logic        sat_cmd = 1'b0, mv_clr = 1'b0;
    logic [51:0] sum_result = '0, acc_cur = '0;
    logic [1:0]  vm_flags;
    logic        mv_flag, sat_we;
    logic [51:0] sat_value;
    logic [23:0] rd_data;

    int    n_checks = 0, n_fail = 0;
    bit    done = 0;
    string tag = "R3";

    // Reference state
    bit m_vm [2];
    bit m_mv;

    acc_ovf_sat i_acc_ovf_sat (
        .clk(clk), .rst_n(rst_n), .mode16(mode16), .bank_sel(bank_sel),
        .prot_en(prot_en), .acc_wr(acc_wr), .sum_result(sum_result),
        .sum_cin_msb(sum_cin_msb), .sum_cout_msb(sum_cout_msb),
        .acc_cur(acc_cur), .sat_cmd(sat_cmd), .mv_clr(mv_clr),
        .vm_flags(vm_flags), .mv_flag(mv_flag), .sat_we(sat_we),
        .sat_value(sat_value), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit spills(input logic [51:0] v, input int lo);
        for (int b = lo; b < 51; b++)
            if (v[b] != v[51]) return 1;
        return 0;
    endfunction

    function automatic logic [51:0] limit_of(input bit narrow, input bit neg);
        if (!narrow) return neg ? 52'hF_8000_0000_0000 : 52'h0_7FFF_FFFF_FFFF;
        return neg ? 52'hF_FF80_0000_0000 : 52'h0_007F_FFFF_FF00;
    endfunction

    // Reference model update at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_vm[0] = 0; m_vm[1] = 0; m_mv = 0;
        end else begin
            if (acc_wr) m_vm[bank_sel] = spills(sum_result, mode16 ? 39 : 47);
            else if (sat_cmd && m_vm[bank_sel]) m_vm[bank_sel] = 0;
            if (acc_wr && (sum_cin_msb != sum_cout_msb)) m_mv = 1;
            else if (mv_clr) m_mv = 0;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit          e_we;
        logic [51:0] e_val;
        logic [23:0] e_rd;
        logic [51:0] lim;
        lim   = limit_of(mode16, acc_cur[51]);
        e_we  = sat_cmd && m_vm[bank_sel];
        e_val = e_we ? lim : acc_cur;
        e_rd  = (prot_en && m_vm[bank_sel]) ? lim[47:24] : acc_cur[47:24];
        check(tag, "vm_flags", 64'(vm_flags), 64'({m_vm[1], m_vm[0]}));
        check(tag, "mv_flag", 64'(mv_flag), 64'(m_mv));
        check(tag, "sat_we", 64'(sat_we), 64'(e_we));
        check(tag, "sat_value", 64'(sat_value), 64'(e_val));
        check(tag, "rd_data", 64'(rd_data), 64'(e_rd));
    endtask

    // Drive one cycle of inputs at the falling edge, then compare.
    task automatic cyc(input bit wr, input logic [51:0] res, input bit ci,
                       input bit co, input bit sat, input bit clr,
                       input logic [51:0] cur);
        @(negedge clk);
        acc_wr = wr; sum_result = res; sum_cin_msb = ci; sum_cout_msb = co;
        sat_cmd = sat; mv_clr = clr; acc_cur = cur;
        #1;
        compare_all();
    endtask

    task automatic idle();
        cyc(0, '0, 0, 0, 0, 0, 52'h0_0012_3456_789A);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        tag = "R3"; idle();
        // R1: wide-mode thresholds on both accumulators
        tag = "R1"; mode16 = 0; bank_sel = 0;
        cyc(1, 52'hF_8000_0000_0000, 0, 0, 0, 0, '0); idle();
        cyc(1, 52'h0_8000_0000_0000, 0, 0, 0, 0, '0); idle();
        bank_sel = 1;
        cyc(1, 52'h0_7FFF_FFFF_FFFF, 0, 0, 0, 0, '0); idle();
        cyc(1, 52'hE_FFFF_FFFF_FFFF, 0, 0, 0, 0, '0); idle();
        // R2: narrow-mode thresholds
        tag = "R2"; mode16 = 1; bank_sel = 0;
        cyc(1, 52'h0_007F_FFFF_FFFF, 0, 0, 0, 0, '0); idle();
        cyc(1, 52'h0_0080_0000_0000, 0, 0, 0, 0, '0); idle();
        cyc(1, 52'hF_FF80_0000_0000, 0, 0, 0, 0, '0); idle();
        cyc(1, 52'hF_FF7F_FFFF_FFFF, 0, 0, 0, 0, '0); idle();
        // R5: saturate with flag clear has no effect
        tag = "R5"; bank_sel = 1; mode16 = 0;
        cyc(1, 52'h0_0000_0000_0001, 0, 0, 0, 0, '0);
        cyc(0, '0, 0, 0, 1, 0, 52'h0_1234_5678_9ABC); idle();
        // R6: wide saturate, positive and negative
        tag = "R6"; bank_sel = 0;
        cyc(1, 52'h1_0000_0000_0000, 0, 0, 0, 0, '0);
        cyc(0, '0, 0, 0, 1, 0, 52'h1_0000_0000_0000); idle();
        cyc(1, 52'h8_0000_0000_0000, 0, 0, 0, 0, '0);
        cyc(0, '0, 0, 0, 1, 0, 52'h8_0000_0000_0000);
        tag = "R8"; idle();
        // R7: narrow saturate
        tag = "R7"; mode16 = 1;
        cyc(1, 52'h0_0100_0000_0000, 0, 0, 0, 0, '0);
        cyc(0, '0, 0, 0, 1, 0, 52'h0_0100_0000_0000); idle();
        cyc(1, 52'hF_FE00_0000_0000, 0, 0, 0, 0, '0);
        cyc(0, '0, 0, 0, 1, 0, 52'hF_FE00_0000_0000); idle();
        // R8: write and saturate together, write wins
        tag = "R8";
        cyc(1, 52'h0_1000_0000_0000, 0, 0, 0, 0, '0);
        cyc(1, 52'h0_1000_0000_0000, 0, 0, 1, 0, 52'h0_1000_0000_0000); idle();
        // R9: clamped reads in wide mode
        tag = "R9"; mode16 = 0; prot_en = 1;
        cyc(1, 52'h2_0000_0000_0000, 0, 0, 0, 0, 52'h2_0000_0000_0000);
        cyc(0, '0, 0, 0, 0, 0, 52'h2_0000_0000_0000);
        cyc(0, '0, 0, 0, 0, 0, 52'hD_0000_0000_0000);
        prot_en = 0;
        cyc(0, '0, 0, 0, 0, 0, 52'hD_0000_0000_0000); prot_en = 1;
        // R10: clamped reads in narrow mode
        tag = "R10"; mode16 = 1;
        cyc(0, '0, 0, 0, 0, 0, 52'h0_0300_0000_0000);
        cyc(0, '0, 0, 0, 0, 0, 52'hF_F000_0000_0000);
        prot_en = 0; idle();
        // R4: sticky flag, clear, set wins over clear
        tag = "R4";
        cyc(1, 52'h7_0000_0000_0000, 1, 0, 0, 0, '0); idle(); idle();
        cyc(0, '0, 0, 0, 0, 1, '0); idle();
        cyc(1, 52'h8_0000_0000_0000, 0, 1, 0, 1, '0); idle();
        cyc(0, '0, 0, 0, 0, 1, '0); idle();
        // Random mix of every strobe
        tag = "R3";
        for (int k = 0; k < 3000; k++) begin
            logic [51:0] r;
            r = {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0: r = {{13{r[51]}}, r[38:0]};
                1: r = {{5{r[51]}}, r[46:0]};
                default: ;
            endcase
            mode16 = 1'($urandom); bank_sel = 1'($urandom);
            prot_en = 1'($urandom);
            cyc(($urandom_range(0, 2) == 0), r, 1'($urandom), 1'($urandom),
                1'($urandom), ($urandom_range(0, 7) == 0),
                {$urandom, $urandom});
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule